// File: doc/BRIEF.md
# Stack Register Renaming Unit

This unit sits beside the decode stage of a processor whose operands live on a three-entry evaluation stack. Three physical registers (numbered 0, 1 and 2) back the stack positions top, second and third. Each decoded instruction is described by a 3-bit operation code. The unit answers three questions for that instruction: which physical register each stack position names, which physical register receives its result, and which older in-flight instructions write a register it reads. Pushes, pops and exchanges are carried out by permuting the name map. No data moves between physical registers, so a result keeps its register for its whole life in the pipeline, and moved data never causes a false dependency.

A copy of the map travels with every instruction through `STAGES` downstream stages. Stage 0 is the youngest stage and stage `STAGES-1` the oldest. On a flush, the map is rebuilt from the snapshot of the youngest surviving stage. If every stage is discarded, the map is rebuilt from the snapshot of the last instruction that left the pipeline.

Top module: `stack_rename`

## Requirements
- R1: After reset the map is top=0, second=1, third=2, `dst_we` is 0 and `dep_hit` is all zero.
- R2: The three map fields always hold a permutation of {0,1,2}.
- R3: Code 1 (push, no source): `dst_we`=1 and `dst_phys` equals the old third register; after the edge top=old third, second=old top, third=old second.
- R4: Code 2 (pop, no source, no write): after the edge top=old second, second=old third, third=old top.
- R5: Code 3 (exchange, no source, no write): after the edge top and second trade registers; third is unchanged.
- R6: Code 4 (unary, reads top): result written in place, so `dst_phys`=top with `dst_we`=1; the map is unchanged.
- R7: Code 5 (binary, reads top and second): `dst_phys`=top with `dst_we`=1; after the edge top is kept, second=old third, third=old second.
- R8: Codes 0, 6 and 7, and any cycle with `in_valid` low, leave the map unchanged, give `dst_we`=0 and raise no hit.
- R9: `dep_hit[i]` is 1 exactly when stage i holds a valid writing instruction whose destination equals a register that the decoding instruction reads; stage i holds the instruction accepted i+1 cycles earlier, with no flush in between.
- R10: With `flush`=1 and `flush_keep`=k>0, the oldest k stages survive and the younger ones are emptied. The map is restored from stage `STAGES-k`. The pipeline does not advance, and the decoding instruction is discarded, with no write and no hits.
- R11: With `flush`=1 and `flush_keep`=0, every stage is emptied. The map is restored to the snapshot of the last instruction that left the oldest stage, or to the reset map if none has left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decode slot holds an instruction |
| in_op | input | 3 | Stack effect code of the decoding instruction |
| flush | input | 1 | Discard younger stages and restore the map |
| flush_keep | input | $clog2(STAGES+1) | Number of oldest stages that survive a flush |
| map_a | output | 2 | Physical register now at the stack top |
| map_b | output | 2 | Physical register now second |
| map_c | output | 2 | Physical register now third |
| dst_we | output | 1 | Decoding instruction writes a result |
| dst_phys | output | 2 | Physical register receiving that result |
| dep_hit | output | STAGES | Per-stage true-dependency flags |

## Verification
A wrong rotation shows on the map ports one edge after the offending operation. A map that is not a permutation shows as a duplicated register number at the same point. A stage snapshot or destination that is stored wrongly stays hidden until later. The bad destination appears as a missing or extra `dep_hit` bit while the instruction is still in the pipeline, up to `STAGES` cycles later. The bad snapshot appears as a wrong map directly after a flush that restores from it. For this reason the bench issues sources that match only flushed or only surviving stages, and flushes to a partial depth and to an empty pipeline.

// File: rtl/stack_rename.sv
module stack_rename #(
  parameter int STAGES = 3,
  localparam int KW = $clog2(STAGES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic              flush,
  input  logic [KW-1:0]     flush_keep,
  output logic [1:0]        map_a,
  output logic [1:0]        map_b,
  output logic [1:0]        map_c,
  output logic              dst_we,
  output logic [1:0]        dst_phys,
  output logic [STAGES-1:0] dep_hit
);
  localparam logic [5:0] MAP_RST = {2'd0, 2'd1, 2'd2};

  logic [5:0] map_q, map_nx, restore, retired_q;
  logic       act, rd_a, rd_b, wr;
  logic [1:0] dst;

  logic             stg_v [STAGES];
  logic             stg_w [STAGES];
  logic [1:0]       stg_d [STAGES];
  logic [5:0]       stg_m [STAGES];

  assign {map_a, map_b, map_c} = map_q;
  assign act = in_valid & ~flush;

  always_comb begin
    map_nx = map_q;
    wr     = 1'b0;
    dst    = 2'd0;
    rd_a   = 1'b0;
    rd_b   = 1'b0;
    if (act) begin
      case (in_op)
        3'd1: begin map_nx = {map_c, map_a, map_b}; wr = 1'b1; dst = map_c; end
        3'd2: map_nx = {map_b, map_c, map_a};
        3'd3: map_nx = {map_b, map_a, map_c};
        3'd4: begin wr = 1'b1; dst = map_a; rd_a = 1'b1; end
        3'd5: begin map_nx = {map_a, map_c, map_b}; wr = 1'b1; dst = map_a; rd_a = 1'b1; rd_b = 1'b1; end
        default: ;
      endcase
    end
  end

  assign dst_we   = wr;
  assign dst_phys = dst;

  always_comb begin
    restore = retired_q;
    for (int i = 0; i < STAGES; i++)
      if (flush_keep != '0 && i == STAGES - int'(flush_keep)) restore = stg_m[i];
  end

  for (genvar g = 0; g < STAGES; g++) begin : g_hit
    assign dep_hit[g] = stg_v[g] & stg_w[g] &
                        ((rd_a & (stg_d[g] == map_a)) | (rd_b & (stg_d[g] == map_b)));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q     <= MAP_RST;
      retired_q <= MAP_RST;
      for (int i = 0; i < STAGES; i++) begin
        stg_v[i] <= 1'b0;
        stg_w[i] <= 1'b0;
        stg_d[i] <= 2'd0;
        stg_m[i] <= MAP_RST;
      end
    end else if (flush) begin
      map_q <= restore;
      for (int i = 0; i < STAGES; i++)
        if (i < STAGES - int'(flush_keep)) begin
          stg_v[i] <= 1'b0;
          stg_w[i] <= 1'b0;
          stg_m[i] <= restore;
        end
    end else begin
      map_q     <= map_nx;
      retired_q <= stg_m[STAGES-1];
      stg_v[0]  <= act;
      stg_w[0]  <= wr;
      stg_d[0]  <= dst;
      stg_m[0]  <= map_nx;
      for (int i = 1; i < STAGES; i++) begin
        stg_v[i] <= stg_v[i-1];
        stg_w[i] <= stg_w[i-1];
        stg_d[i] <= stg_d[i-1];
        stg_m[i] <= stg_m[i-1];
      end
    end
  end
endmodule

// File: rtl/stack_rename_chk.sv
module stack_rename_chk #(
  parameter int STAGES = 3,
  localparam int KW = $clog2(STAGES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        in_op,
  input logic              flush,
  input logic [KW-1:0]     flush_keep,
  input logic [1:0]        map_a,
  input logic [1:0]        map_b,
  input logic [1:0]        map_c,
  input logic              dst_we,
  input logic [1:0]        dst_phys,
  input logic [STAGES-1:0] dep_hit
);
  logic act;
  assign act = in_valid & ~flush;

  assert_perm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    map_a != map_b && map_b != map_c && map_a != map_c &&
    map_a != 2'd3 && map_b != 2'd3 && map_c != 2'd3);

  assert_push_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act && in_op == 3'd1 |=> map_a == $past(map_c) && map_b == $past(map_a) && map_c == $past(map_b));

  assert_push_dst_R3: assert property (@(posedge clk) disable iff (!rst_n)
    act && in_op == 3'd1 |-> dst_we && dst_phys == map_c);

  assert_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act && in_op == 3'd2 |=> map_a == $past(map_b) && map_b == $past(map_c) && map_c == $past(map_a));

  assert_swap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act && in_op == 3'd3 |=> map_a == $past(map_b) && map_b == $past(map_a) && $stable(map_c));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && !flush |=> $stable(map_a) && $stable(map_b) && $stable(map_c));

  assert_no_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> dep_hit == '0 && !dst_we);

  logic unused_ok;
  assign unused_ok = ^flush_keep;
endmodule

bind stack_rename stack_rename_chk #(.STAGES(STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .flush(flush),
  .flush_keep(flush_keep), .map_a(map_a), .map_b(map_b), .map_c(map_c),
  .dst_we(dst_we), .dst_phys(dst_phys), .dep_hit(dep_hit));

// File: tb/stack_rename_test.sv
module stack_rename_test;
  localparam int N = 3;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, flush = 1'b0;
  logic [2:0] in_op = 3'd0;
  logic [1:0] flush_keep = 2'd0;
  logic [1:0] map_a, map_b, map_c, dst_phys;
  logic dst_we;
  logic [N-1:0] dep_hit;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stack_rename #(.STAGES(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .flush(flush),
    .flush_keep(flush_keep), .map_a(map_a), .map_b(map_b), .map_c(map_c),
    .dst_we(dst_we), .dst_phys(dst_phys), .dep_hit(dep_hit));

  // {op[3], we, dst[2], a[2], b[2], c[2], hit[3]}; map is the value after the edge
  localparam logic [14:0] VEC [10] = '{
    15'b001_1_10_10_00_01_000,
    15'b001_1_01_01_10_00_000,
    15'b011_0_00_10_01_00_000,
    15'b010_0_00_01_00_10_000,
    15'b101_1_01_01_10_00_100,
    15'b100_1_01_01_10_00_001,
    15'b000_0_00_01_10_00_000,
    15'b111_0_00_01_10_00_000,
    15'b010_0_00_10_00_01_000,
    15'b001_1_01_01_10_00_000
  };

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_map(string tag, int a, int b, int c);
    chk({tag, " top"}, map_a, a);
    chk({tag, " second"}, map_b, b);
    chk({tag, " third"}, map_c, c);
  endtask

  task automatic drive(logic v, logic [2:0] op, logic fl, logic [1:0] keep);
    @(negedge clk);
    in_valid = v; in_op = op; flush = fl; flush_keep = keep;
    #1;
  endtask

  task automatic edge_then_sample();
    @(posedge clk);
    #1;
    in_valid = 1'b0; flush = 1'b0;
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk_map("R1 reset map", 0, 1, 2);
    chk("R1 reset dst_we", dst_we, 0);
    chk("R1 reset hits", dep_hit, 0);

    for (int i = 0; i < 10; i++) begin
      drive(1'b1, VEC[i][14:12], 1'b0, 2'd0);
      chk($sformatf("R9 row %0d hits", i), dep_hit, VEC[i][2:0]);
      chk($sformatf("R3/R6/R7/R8 row %0d we", i), dst_we, VEC[i][11]);
      if (VEC[i][11]) chk($sformatf("R3/R6/R7 row %0d dst", i), dst_phys, VEC[i][10:9]);
      edge_then_sample();
      chk_map($sformatf("R3/R4/R5/R7/R8 row %0d", i), VEC[i][8:7], VEC[i][6:5], VEC[i][4:3]);
      chk($sformatf("R2 row %0d distinct", i), int'(map_a != map_b && map_b != map_c && map_a != map_c), 1);
    end

    drive(1'b0, 3'd1, 1'b0, 2'd0);
    chk("R8 invalid push no write", dst_we, 0);
    edge_then_sample();
    chk_map("R8 invalid push map", 1, 2, 0);

    // fresh start for flush tests
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    drive(1'b1, 3'd1, 1'b0, 2'd0); edge_then_sample();
    drive(1'b1, 3'd1, 1'b0, 2'd0); edge_then_sample();
    drive(1'b1, 3'd1, 1'b0, 2'd0);
    chk("R3 third push dst", dst_phys, 0);
    edge_then_sample();
    chk_map("R3 three pushes", 0, 1, 2);

    drive(1'b1, 3'd5, 1'b1, 2'd1);
    chk("R10 discarded write", dst_we, 0);
    chk("R10 discarded hits", dep_hit, 0);
    edge_then_sample();
    chk_map("R10 restore keep1", 2, 0, 1);

    drive(1'b1, 3'd5, 1'b0, 2'd0);
    chk("R10 only survivor hits", dep_hit, 3'b100);
    chk("R7 binary dst", dst_phys, 2);
    edge_then_sample();
    chk_map("R7 binary map", 2, 1, 0);

    drive(1'b1, 3'd1, 1'b1, 2'd0);
    edge_then_sample();
    chk_map("R11 restore retired", 2, 0, 1);

    drive(1'b1, 3'd5, 1'b0, 2'd0);
    chk("R11 empty pipeline hits", dep_hit, 0);
    edge_then_sample();

    drive(1'b1, 3'd4, 1'b0, 2'd0);
    chk("R9 unary after binary hit", dep_hit, 3'b001);
    chk("R6 unary dst", dst_phys, 2);
    edge_then_sample();
    chk_map("R6 unary map", 2, 1, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule